// File: doc/BRIEF.md
# Multi-Protocol Synchronous Serial Master

This block is a master-only synchronous serial port. Words to send are pushed into an 8-entry, 16-bit transmit queue. The shift engine takes them one at a time and moves each over the serial pins in one of three framings. The first is a select-based full-duplex framing with the serial clock idling low. The second is a framing marked by a one-clock frame pulse. The third is a half-duplex command/reply framing in which an 8-bit command is sent and a reply is then read back. Received words go into an 8-entry, 16-bit receive queue that software or a DMA engine drains.

The data word length is programmable from 4 to 16 bits. The serial clock is the system clock divided by an even, programmable factor. An internal loopback path ties the transmit line to the receive sampler. Each queue has a DMA request line. One interrupt output combines three masked sources: the transmit level, the receive level and receive overrun.

Top module: `ssp_master`

## Requirements
- R1: Format code 0 (select framing): `sel` is low for the whole frame and high between frames, and `sclk` idles low. The frame has exactly N clock periods. Data goes out most significant bit first, `mosi` changes only on falling `sclk` or when a frame starts, and `miso` is sampled on each rising `sclk`.
- R2: Format code 1 (pulse framing): `sel` is low when idle and goes high for exactly the first serial clock period of the frame, with `mosi` at 0 during that period. N data periods follow, with the same edge usage as R1, so the frame has N+1 periods.
- R3: Format code 2 (command/reply framing): `sel` is low for 8+N periods. The first 8 periods send bits 7..0 of the transmit word, most significant first. During the following N periods `mosi` is 0 and `miso` is sampled. The received word holds only those N bits.
- R4: `cfg_len` holds N-1. A value below 3 is treated as 3, so N is 4. In formats 0 and 1 only bits N-1..0 of a transmit word are sent, and every received word is zero-extended to 16 bits.
- R5: Each half period of `sclk` lasts `cfg_div`/2 system clock cycles, with bit 0 of `cfg_div` ignored. A value below 2 acts as 2.
- R6: The transmit queue holds 8 words and `tx_full` reports when it is full. A push while the queue is full is dropped unless the engine takes a word in the same cycle.
- R7: `rx_valid` is high while the receive queue holds a word, and `rx_data` shows the oldest word. A pulse on `rx_pop` removes that word. Words come out in the order they were received.
- R8: If a frame finishes while the receive queue is full and no `rx_pop` occurs in that cycle, the new word is discarded and a sticky overrun flag is set. A pulse on `ovr_clr` clears the flag. If `rx_pop` occurs in the same cycle, the word is stored and no overrun is flagged.
- R9: `irq` is the OR of three sources, each gated by its own mask bit: bit 0 of `int_mask` gates transmit count <= 4, bit 1 gates receive count >= 4, and bit 2 gates the overrun flag.
- R10: With `cfg_loop` = 1, the sampler reads the port's own `mosi` and `miso` has no effect.
- R11: `tx_dreq` = `en` and not full. `rx_dreq` is high while the receive queue is not empty.
- R12: After reset, `sel` is inactive, `sclk` is low, and both queues and the overrun flag are empty. A frame starts only while `en` = 1 and a transmit word is waiting. The select stays inactive for at least one system cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Allows frames to start |
| cfg_mode | input | 2 | Framing: 0 select, 1 pulse, 2 command/reply, 3 acts as 0 |
| cfg_len | input | 4 | Data word length minus one |
| cfg_div | input | 8 | Serial clock divisor, even, at least 2 |
| cfg_loop | input | 1 | Internal loopback enable |
| int_mask | input | 3 | Interrupt enables: transmit level, receive level, overrun |
| ovr_clr | input | 1 | Clears the overrun flag |
| tx_push | input | 1 | Writes `tx_data` into the transmit queue |
| tx_data | input | 16 | Word to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Removes the oldest received word |
| rx_data | output | 16 | Oldest received word |
| rx_valid | output | 1 | Receive queue not empty |
| sclk | output | 1 | Serial clock |
| sel | output | 1 | Select (formats 0 and 2) or frame pulse (format 1) |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| irq | output | 1 | Combined masked interrupt |

## Verification
The end of a frame can fall in the same cycle as an `rx_pop` on a full receive queue. In that cycle the queue is written and read at once, and the overrun decision has to take the pop into account. The bench fills the receive queue through loopback frames and queues one more word. It then waits for the select to assert and counts the exact number of system cycles to the final falling clock edge, so that it can raise `rx_pop` in that cycle. It judges the result in three ways: the overrun interrupt must stay low, the popped word must be the oldest one, and the late word must come out last.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        FMT_SEL  = 2'd0,
        FMT_PULS = 2'd1,
        FMT_CMD  = 2'd2,
        FMT_RSV  = 2'd3
    } fmt_e;

    localparam int CMD_BITS = 8;
    localparam int MIN_BITS = 4;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  wr, rd;

    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign dout  = s_q.mem[s_q.rp];
    assign count = s_q.cnt;

    always_comb begin
        s_d = s_q;
        rd  = pop && !empty;
        wr  = push && (!full || rd);
        if (wr) begin
            s_d.mem[s_q.wp] = din;
            s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + AW'(1);
        end
        if (rd) begin
            s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + AW'(1);
        end
        case ({wr, rd})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t             s_d, s_q;
    logic [DIV_W-1:0] half;

    always_comb begin
        s_d  = s_q;
        half = div >> 1;
        if (half == '0) half = DIV_W'(1);
        tick = run && (s_q.cnt == half - DIV_W'(1));
        if (!run || tick) s_d.cnt = '0;
        else              s_d.cnt = s_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
    import ssp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NB_W   = $clog2(DATA_W + 1),
    parameter int CNT_W  = $clog2(DATA_W + CMD_BITS + 1),
    parameter int SKIP_W = $clog2(CMD_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  fmt_e              fmt_in,
    input  logic              idle_puls,
    input  logic [NB_W-1:0]   nbits,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tick,
    input  logic              rx_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              sel,
    output logic              mosi
);
    typedef struct packed {
        logic              busy;
        fmt_e              fmt;
        logic              pre;
        logic              sclk;
        logic [CNT_W-1:0]  cnt;
        logic [SKIP_W-1:0] skip;
        logic [DATA_W-1:0] txsr;
        logic [DATA_W-1:0] rxsr;
    } eng_t;

    eng_t s_d, s_q;
    logic done_c;

    always_comb begin
        s_d    = s_q;
        done_c = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.fmt  = fmt_in;
                s_d.pre  = (fmt_in == FMT_PULS);
                s_d.sclk = 1'b0;
                s_d.rxsr = '0;
                case (fmt_in)
                    FMT_PULS: begin
                        s_d.cnt  = CNT_W'(nbits) + CNT_W'(1);
                        s_d.skip = SKIP_W'(1);
                        s_d.txsr = tx_word << (DATA_W - int'(nbits));
                    end
                    FMT_CMD: begin
                        s_d.cnt  = CNT_W'(nbits) + CNT_W'(CMD_BITS);
                        s_d.skip = SKIP_W'(CMD_BITS);
                        s_d.txsr = DATA_W'(tx_word[CMD_BITS-1:0]) << (DATA_W - CMD_BITS);
                    end
                    default: begin
                        s_d.cnt  = CNT_W'(nbits);
                        s_d.skip = '0;
                        s_d.txsr = tx_word << (DATA_W - int'(nbits));
                    end
                endcase
            end
        end else if (tick) begin
            if (!s_q.sclk) begin
                // rising edge: sample once the skip window has passed
                s_d.sclk = 1'b1;
                if (s_q.skip == '0) s_d.rxsr = {s_q.rxsr[DATA_W-2:0], rx_in};
            end else begin
                // falling edge: advance output and period count
                s_d.sclk = 1'b0;
                if (s_q.pre) s_d.pre  = 1'b0;
                else         s_d.txsr = s_q.txsr << 1;
                if (s_q.skip != '0) s_d.skip = s_q.skip - SKIP_W'(1);
                s_d.cnt = s_q.cnt - CNT_W'(1);
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.busy = 1'b0;
                    done_c   = 1'b1;
                end
            end
        end
    end

    assign busy    = s_q.busy;
    assign done    = done_c;
    assign rx_word = s_q.rxsr;
    assign sclk    = s_q.sclk;
    assign mosi    = s_q.busy && !s_q.pre && s_q.txsr[DATA_W-1];
    assign sel     = s_q.busy ? ((s_q.fmt == FMT_PULS) ? s_q.pre : 1'b0) : !idle_puls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ssp_master.sv
module ssp_master
    import ssp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int DIV_W  = 8,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        cfg_mode,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_loop,
    input  logic [2:0]        int_mask,
    input  logic              ovr_clr,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_full,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sclk,
    output logic              sel,
    output logic              mosi,
    input  logic              miso,
    output logic              tx_dreq,
    output logic              rx_dreq,
    output logic              irq
);
    localparam int NB_W = $clog2(DATA_W + 1);
    localparam int CW   = $clog2(DEPTH + 1);

    typedef struct packed {
        logic ovr;
    } top_t;

    top_t              s_d, s_q;
    fmt_e              fmt;
    logic [LEN_W-1:0]  len_eff;
    logic [NB_W-1:0]   nbits;
    logic              start, eng_busy, eng_done, tick, rx_in;
    logic [DATA_W-1:0] tx_head, rx_word;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_empty, rx_full, rx_empty;
    logic              ovr_flag;

    always_comb begin
        fmt     = (cfg_mode == 2'd3) ? FMT_SEL : fmt_e'(cfg_mode);
        len_eff = (cfg_len < LEN_W'(MIN_BITS - 1)) ? LEN_W'(MIN_BITS - 1) : cfg_len;
        nbits   = NB_W'(len_eff) + NB_W'(1);
    end

    assign start = en && !eng_busy && !tx_empty;
    assign rx_in = cfg_loop ? mosi : miso;

    ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_data), .pop(start),
        .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    ssp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(eng_done), .din(rx_word), .pop(rx_pop),
        .dout(rx_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    ssp_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(cfg_div), .tick(tick)
    );

    ssp_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_in(fmt),
        .idle_puls(fmt == FMT_PULS), .nbits(nbits), .tx_word(tx_head),
        .tick(tick), .rx_in(rx_in), .busy(eng_busy), .done(eng_done),
        .rx_word(rx_word), .sclk(sclk), .sel(sel), .mosi(mosi)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ovr = (s_q.ovr && !ovr_clr) || (eng_done && rx_full && !rx_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ovr_flag = s_q.ovr;
    assign rx_valid = !rx_empty;
    assign rx_dreq  = !rx_empty;
    assign tx_dreq  = en && !tx_full;
    assign irq      = (int_mask[0] && (tx_cnt <= CW'(DEPTH / 2)))
                    || (int_mask[1] && (rx_cnt >= CW'(DEPTH / 2)))
                    || (int_mask[2] && ovr_flag);
endmodule

// File: rtl/ssp_master_chk.sv
module ssp_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic [1:0] cfg_mode,
    input logic       sclk,
    input logic       sel,
    input logic       mosi,
    input logic       tx_full,
    input logic       tx_dreq,
    input logic [2:0] int_mask,
    input logic       irq,
    input logic       eng_done,
    input logic       rx_full,
    input logic       rx_pop,
    input logic       ovr_flag
);
    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != 2'd1 && sel) |-> !sclk);                               // R1
    AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1 && $stable(cfg_mode) && $fell(sel)) |-> $fell(sclk)); // R2
    AST_MOSI_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> ($fell(sclk) || !$stable(sel)));                 // R1
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && rx_full && !rx_pop) |=> ovr_flag);                     // R8
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == 3'b000) |-> !irq);                                     // R9
    AST_DREQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !tx_dreq);                                              // R11
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && sel && cfg_mode == 2'd0) |=> (sel || cfg_mode != 2'd0));   // R12
endmodule

bind ssp_master ssp_master_chk i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_mode(cfg_mode), .sclk(sclk),
    .sel(sel), .mosi(mosi), .tx_full(tx_full), .tx_dreq(tx_dreq),
    .int_mask(int_mask), .irq(irq), .eng_done(eng_done), .rx_full(rx_full),
    .rx_pop(rx_pop), .ovr_flag(ovr_flag)
);

// File: tb/test_ssp_master.sv
module test_ssp_master;
    logic        clk = 1'b0;
    logic        rst_n, en, cfg_loop, ovr_clr, tx_push, rx_pop, miso;
    logic [1:0]  cfg_mode;
    logic [3:0]  cfg_len;
    logic [7:0]  cfg_div;
    logic [2:0]  int_mask;
    logic [15:0] tx_data, rx_data;
    logic        tx_full, rx_valid, sclk, sel, mosi, tx_dreq, rx_dreq, irq;

    always #5 clk = ~clk;

    ssp_master i_ssp_master (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_mode(cfg_mode), .cfg_len(cfg_len),
        .cfg_div(cfg_div), .cfg_loop(cfg_loop), .int_mask(int_mask), .ovr_clr(ovr_clr),
        .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .sel(sel), .mosi(mosi),
        .miso(miso), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  len;
        logic [7:0]  div;
        logic        loop;
        logic [15:0] tx;
        logic [15:0] pat;
        logic [15:0] exp_rx;
        logic [31:0] exp_cap;
        logic [7:0]  exp_hi;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 4'd7,  8'd2, 1'b0, 16'h00A5, 16'h3C00, 16'h003C, 32'h000000A5, 8'd8},
        '{2'd0, 4'd15, 8'd5, 1'b0, 16'hBEEF, 16'h1234, 16'h1234, 32'h0000BEEF, 8'd32},
        '{2'd0, 4'd3,  8'd6, 1'b1, 16'hFFF9, 16'hFFFF, 16'h0009, 32'h00000009, 8'd12},
        '{2'd1, 4'd7,  8'd2, 1'b0, 16'h0081, 16'hABCD, 16'h0057, 32'h00000081, 8'd9},
        '{2'd2, 4'd7,  8'd2, 1'b0, 16'h00C3, 16'h5A96, 16'h0096, 32'h0000C300, 8'd16},
        '{2'd2, 4'd11, 8'd4, 1'b0, 16'h1234, 16'hFF5A, 16'h05A0, 32'h00034000, 8'd40},
        '{2'd1, 4'd15, 8'd2, 1'b1, 16'hC0DE, 16'h0000, 16'hC0DE, 32'h0000C0DE, 8'd17},
        '{2'd0, 4'd1,  8'd0, 1'b1, 16'h0006, 16'h0000, 16'h0006, 32'h00000006, 8'd4}
    };

    int total = 0;
    int bad   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // serial peer model and line capture, all at the falling system clock edge
    logic [15:0] slv = '0;
    logic [15:0] pat = '0;
    logic [31:0] cap = '0;
    int          hi  = 0;
    logic        act_prev = 1'b0;
    logic        sclk_prev = 1'b0;
    assign miso = slv[15];

    always @(negedge clk) begin
        logic act;
        act = (cfg_mode == 2'd1) ? sel : !sel;
        if (act && !act_prev) begin
            slv = pat;
            cap = '0;
            hi  = 0;
        end else if (sclk_prev && !sclk) begin
            slv = slv << 1;
        end
        if (!sclk_prev && sclk) cap = {cap[30:0], mosi};
        if (sclk) hi++;
        act_prev  = act;
        sclk_prev = sclk;
    end

    task automatic push(input logic [15:0] v);
        tx_data = v;
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [15:0] v);
        chk(req, rx_data, v);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; cfg_loop = 1'b0; ovr_clr = 1'b0;
        tx_push = 1'b0; rx_pop = 1'b0; cfg_mode = 2'd0; cfg_len = 4'd7;
        cfg_div = 8'd2; int_mask = 3'b000; tx_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 sel idle", {31'd0, sel}, 1);
        chk("R12 sclk idle", {31'd0, sclk}, 0);
        chk("R12 rx empty", {31'd0, rx_valid}, 0);
        chk("R11 rx_dreq", {31'd0, rx_dreq}, 0);
        chk("R9 irq unmasked", {31'd0, irq}, 0);
        int_mask = 3'b001; #1;
        chk("R9 tx level irq", {31'd0, irq}, 1);
        int_mask = 3'b000;
        en = 1'b1; #1;
        chk("R11 tx_dreq", {31'd0, tx_dreq}, 1);
        en = 1'b0;
        @(negedge clk);

        // vector table: one frame each
        for (int i = 0; i < 8; i++) begin
            string tag;
            vec_t  v;
            v = VECS[i];
            tag = v.loop ? "R10" : (v.mode == 2'd1) ? "R2" : (v.mode == 2'd2) ? "R3" : "R1";
            cfg_mode = v.mode; cfg_len = v.len; cfg_div = v.div; cfg_loop = v.loop;
            pat = v.pat;
            @(negedge clk);
            push(v.tx);
            en = 1'b1;
            for (int w = 0; w < 400 && !rx_valid; w++) @(negedge clk);
            chk($sformatf("%s vec%0d rx word", tag, i), {16'd0, rx_data}, {16'd0, v.exp_rx});
            chk($sformatf("R4 vec%0d line bits", i), cap, v.exp_cap);
            chk($sformatf("R5 vec%0d sclk high cycles", i), hi, {24'd0, v.exp_hi});
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
            chk($sformatf("R7 vec%0d drained", i), {31'd0, rx_valid}, 0);
            en = 1'b0;
            @(negedge clk);
        end

        // fill queues, push to full, overrun
        cfg_mode = 2'd0; cfg_len = 4'd15; cfg_div = 8'd2; cfg_loop = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) push(16'h0100 + 16'(i));
        push(16'hDEAD);
        chk("R6 tx full", {31'd0, tx_full}, 1);
        repeat (10) @(negedge clk);
        chk("R12 no start while disabled", {31'd0, sel}, 1);
        en = 1'b1; #1;
        chk("R11 tx_dreq low when full", {31'd0, tx_dreq}, 0);
        repeat (400) @(negedge clk);
        chk("R11 rx_dreq", {31'd0, rx_dreq}, 1);
        int_mask = 3'b010; #1;
        chk("R9 rx level irq", {31'd0, irq}, 1);
        int_mask = 3'b100; #1;
        chk("R8 no overrun yet", {31'd0, irq}, 0);
        @(negedge clk);
        push(16'h7777);
        repeat (80) @(negedge clk);
        chk("R8 overrun flagged", {31'd0, irq}, 1);
        for (int i = 0; i < 8; i++) pop_chk("R6 order", 16'h0100 + 16'(i));
        chk("R8 overrun word dropped", {31'd0, rx_valid}, 0);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R8 overrun cleared", {31'd0, irq}, 0);

        // frame end and pop in the same cycle on a full receive queue
        en = 1'b0;
        for (int i = 0; i < 8; i++) push(16'h0200 + 16'(i));
        en = 1'b1;
        repeat (400) @(negedge clk);
        push(16'h0ABC);
        for (int w = 0; w < 50 && sel; w++) @(negedge clk);
        repeat (31) @(negedge clk);
        chk("R8 head at collision", {16'd0, rx_data}, 32'h0200);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 no overrun with pop", {31'd0, irq}, 0);
        for (int i = 1; i < 8; i++) pop_chk("R7 order", 16'h0200 + 16'(i));
        pop_chk("R8 late word kept", 16'h0ABC);
        chk("R7 empty", {31'd0, rx_valid}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule